// File: doc/BRIEF.md
# Timer Compare Channel

This block is one compare channel that sits beside a free-standing up/down timer counter. The counter value comes in as a port. On each enabled timer tick the channel checks whether the counter equals its stored compare value. When they are equal it raises a match flag and updates a single output-compare state bit. Software picks the action with a two-bit mode: set, clear or toggle, or no action at all.

The compare value is wider than the CPU bus, so software writes it in two bytes. The upper byte first goes into a holding byte. The lower-byte write then commits both bytes into the compare register in one clock edge, so the comparator never sees a half-written value. The stored value can be read back directly at any time.

Two control paths let software steer the channel:
- A force strobe drives the state bit exactly as a match would, but it leaves the flag alone.
- A write to the counter masks the next timer tick's match, so software can load the counter equal to the compare value without causing a spurious event.

A nonzero mode also hands the pin from the general port bit to the state bit.

Top module: `oc_unit`

## Requirements
- R1: A write to `hiWrite` stores `wrData` in the holding byte only. `cmpValue` does not change on that write.
- R2: A write to `loWrite` loads `cmpValue` with {holding byte, `wrData`} on the same clock edge. The new value is visible on the next cycle.
- R3: `matchFlag` sets on an edge where `tick` is 1, `cnt` equals `cmpValue`, and no block is pending. Driving `flagClear` to 1 clears it. If set and clear come together, set wins.
- R4: On a match the state bit follows the mode, decoded as follows:
  - 2'b01 toggles it.
  - 2'b10 clears it.
  - 2'b11 sets it.
  - 2'b00 leaves it unchanged.
- R5: `pinOut` depends on `dirBit` and the mode:
  - When `dirBit` is 0, `pinOut` is 0.
  - When `dirBit` is 1 and the mode is 2'b00, `pinOut` equals `portBit`.
  - When `dirBit` is 1 and the mode is nonzero, `pinOut` equals `ocState`.
- R6: `forceStrobe` with `pwmMode` at 0 updates `ocState` exactly as a match would under the current mode. It never sets `matchFlag`. With `pwmMode` at 1 the strobe has no effect.
- R7: A `cntWrite` pulse suppresses the match on the next edge with `tick` at 1, however many tick-less cycles lie between. Later ticks match normally.
- R8: After reset, `ocState`, `matchFlag`, `cmpValue` and the holding byte are all 0.
- R9: The mode is not buffered. The mode present on the match edge is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable |
| cnt | input | 2*BUS_W | Current counter value |
| cntWrite | input | 1 | CPU write to the counter (block strobe) |
| hiWrite | input | 1 | Write upper compare byte to holding byte |
| loWrite | input | 1 | Write lower compare byte and commit |
| wrData | input | BUS_W | CPU write data |
| modeSel | input | 2 | Compare output mode |
| pwmMode | input | 1 | 1 when a PWM waveform mode is active |
| forceStrobe | input | 1 | Force compare strobe |
| flagClear | input | 1 | Write-one-to-clear for the match flag |
| dirBit | input | 1 | Pin direction, 1 = output |
| portBit | input | 1 | General port data bit |
| cmpValue | output | 2*BUS_W | Compare register readback |
| matchFlag | output | 1 | Compare match flag |
| ocState | output | 1 | Output-compare state bit |
| pinOut | output | 1 | Pin drive value |

## Verification
The bench uses the default `BUS_W` of 8, giving a 16-bit compare value built from two bytes. Writing distinct bytes exposes any swap or mix-up between the holding byte and the low byte. At this width, a counter value one below the compare value checks the exact-equality test. Ticks are gated by hand, so the bench can space a counter write several tick-less cycles ahead of the masked tick.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    OC_OFF    = 2'b00,
    OC_TOGGLE = 2'b01,
    OC_CLEAR  = 2'b10,
    OC_SET    = 2'b11
  } ocMode_t;

  typedef struct packed {
    logic loadHi;
    logic commitLo;
    logic setFlag;
    logic clrFlag;
    logic updState;
  } ocStrobe_t;
endpackage

// File: rtl/oc_ctrl.sv
module oc_ctrl
  import oc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      cntWrite,
  input  logic      hiWrite,
  input  logic      loWrite,
  input  logic      forceStrobe,
  input  logic      pwmMode,
  input  logic      flagClear,
  input  logic      cmpEqual,
  output ocStrobe_t strobes
);
  logic blockPending;
  logic matchHit;

  // one-shot mask: armed by a counter write, consumed by the next tick
  always_ff @(posedge clk) begin
    if (!rst_n)        blockPending <= 1'b0;
    else if (cntWrite) blockPending <= 1'b1;
    else if (tick)     blockPending <= 1'b0;
  end

  assign matchHit = tick && cmpEqual && !blockPending;

  always_comb begin
    strobes          = '0;
    strobes.loadHi   = hiWrite;
    strobes.commitLo = loWrite;
    strobes.setFlag  = matchHit;
    strobes.clrFlag  = flagClear;
    strobes.updState = matchHit || (forceStrobe && !pwmMode);
  end
endmodule

// File: rtl/oc_datapath.sv
module oc_datapath
  import oc_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CMP_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] wrData,
  input  logic [CMP_W-1:0] cnt,
  input  ocMode_t          modeSel,
  input  ocStrobe_t        strobes,
  input  logic             dirBit,
  input  logic             portBit,
  output logic [CMP_W-1:0] cmpValue,
  output logic             cmpEqual,
  output logic             matchFlag,
  output logic             ocState,
  output logic             pinOut
);
  logic [BUS_W-1:0] holdHi;
  logic             stateNext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdHi   <= '0;
      cmpValue <= '0;
    end else begin
      if (strobes.loadHi)   holdHi   <= wrData;
      if (strobes.commitLo) cmpValue <= {holdHi, wrData};
    end
  end

  assign cmpEqual = (cnt == cmpValue);

  always_comb begin
    unique case (modeSel)
      OC_TOGGLE: stateNext = !ocState;
      OC_CLEAR:  stateNext = 1'b0;
      OC_SET:    stateNext = 1'b1;
      default:   stateNext = ocState;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ocState   <= 1'b0;
      matchFlag <= 1'b0;
    end else begin
      if (strobes.updState)     ocState   <= stateNext;
      if (strobes.setFlag)      matchFlag <= 1'b1;
      else if (strobes.clrFlag) matchFlag <= 1'b0;
    end
  end

  always_comb begin
    if (!dirBit)               pinOut = 1'b0;
    else if (modeSel == OC_OFF) pinOut = portBit;
    else                       pinOut = ocState;
  end
endmodule

// File: rtl/oc_unit.sv
module oc_unit
  import oc_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CMP_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CMP_W-1:0] cnt,
  input  logic             cntWrite,
  input  logic             hiWrite,
  input  logic             loWrite,
  input  logic [BUS_W-1:0] wrData,
  input  logic [1:0]       modeSel,
  input  logic             pwmMode,
  input  logic             forceStrobe,
  input  logic             flagClear,
  input  logic             dirBit,
  input  logic             portBit,
  output logic [CMP_W-1:0] cmpValue,
  output logic             matchFlag,
  output logic             ocState,
  output logic             pinOut
);
  ocStrobe_t strobes;
  logic      cmpEqual;

  oc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cntWrite(cntWrite),
    .hiWrite(hiWrite), .loWrite(loWrite), .forceStrobe(forceStrobe),
    .pwmMode(pwmMode), .flagClear(flagClear), .cmpEqual(cmpEqual),
    .strobes(strobes)
  );

  oc_datapath #(.BUS_W(BUS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .wrData(wrData), .cnt(cnt),
    .modeSel(ocMode_t'(modeSel)), .strobes(strobes),
    .dirBit(dirBit), .portBit(portBit), .cmpValue(cmpValue),
    .cmpEqual(cmpEqual), .matchFlag(matchFlag), .ocState(ocState),
    .pinOut(pinOut)
  );
endmodule

// File: rtl/oc_unit_chk.sv
module oc_unit_chk #(
  parameter int BUS_W = 8,
  localparam int CMP_W = 2 * BUS_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CMP_W-1:0] cnt,
  input logic             cntWrite,
  input logic             hiWrite,
  input logic             loWrite,
  input logic [BUS_W-1:0] wrData,
  input logic [1:0]       modeSel,
  input logic             pwmMode,
  input logic             forceStrobe,
  input logic             flagClear,
  input logic             dirBit,
  input logic             portBit,
  input logic [CMP_W-1:0] cmpValue,
  input logic             matchFlag,
  input logic             ocState,
  input logic             pinOut
);
  p_hi_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hiWrite && !loWrite) |=> $stable(cmpValue));

  p_lo_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    loWrite |=> cmpValue[BUS_W-1:0] == $past(wrData));

  p_no_spurious_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !matchFlag) |=> !matchFlag);

  p_off_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == 2'b00) |=> $stable(ocState));

  p_pin_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == 2'b00) |-> pinOut == (dirBit && portBit));

  p_force_noflag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (forceStrobe && !tick && !matchFlag) |=> !matchFlag);

  p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(cntWrite) && !matchFlag) |=> !matchFlag);
endmodule

bind oc_unit oc_unit_chk #(.BUS_W(BUS_W)) chk (.*);

// File: tb/oc_unit_test.sv
module oc_unit_test;
  localparam int BUS_W = 8;
  localparam int CMP_W = 2 * BUS_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic [CMP_W-1:0] cnt = '0;
  logic             cntWrite = 1'b0;
  logic             hiWrite = 1'b0;
  logic             loWrite = 1'b0;
  logic [BUS_W-1:0] wrData = '0;
  logic [1:0]       modeSel = 2'b00;
  logic             pwmMode = 1'b0;
  logic             forceStrobe = 1'b0;
  logic             flagClear = 1'b0;
  logic             dirBit = 1'b0;
  logic             portBit = 1'b0;
  logic [CMP_W-1:0] cmpValue;
  logic             matchFlag;
  logic             ocState;
  logic             pinOut;

  int testCnt = 0;
  int failCnt = 0;

  always #2 clk = ~clk;

  oc_unit #(.BUS_W(BUS_W)) uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock edge, then release strobes and settle at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    hiWrite = 0; loWrite = 0; cntWrite = 0; tick = 0;
    forceStrobe = 0; flagClear = 0;
  endtask

  task automatic clearFlag();
    flagClear = 1; step();
  endtask

  task automatic t_reset();
    check(cmpValue == 0, "R8", cmpValue, 0);
    check(matchFlag == 0, "R8", matchFlag, 0);
    check(ocState == 0, "R8", ocState, 0);
  endtask

  task automatic t_write();
    hiWrite = 1; wrData = 8'h12; step();
    check(cmpValue == 0, "R1", cmpValue, 0);
    loWrite = 1; wrData = 8'h34; step();
    check(cmpValue == 16'h1234, "R2", cmpValue, 16'h1234);
    hiWrite = 1; wrData = 8'hAB; step();
    check(cmpValue == 16'h1234, "R1", cmpValue, 16'h1234);
    loWrite = 1; wrData = 8'hCD; step();
    check(cmpValue == 16'hABCD, "R2", cmpValue, 16'hABCD);
    hiWrite = 1; wrData = 8'h12; step();
    loWrite = 1; wrData = 8'h34; step();
  endtask

  task automatic t_match();
    dirBit = 1; modeSel = 2'b01;
    cnt = 16'h1233; tick = 1; step();
    check(matchFlag == 0, "R3", matchFlag, 0);
    cnt = 16'h1234; tick = 1; step();
    check(matchFlag == 1, "R3", matchFlag, 1);
    check(ocState == 1, "R4", ocState, 1);
    check(pinOut == 1, "R5", pinOut, 1);
    clearFlag();
    check(matchFlag == 0, "R3", matchFlag, 0);
    tick = 1; flagClear = 1; step();
    check(matchFlag == 1, "R3", matchFlag, 1);
    check(ocState == 0, "R4", ocState, 0);
    modeSel = 2'b11; tick = 1; step();
    check(ocState == 1, "R4", ocState, 1);
    modeSel = 2'b10; tick = 1; step();
    check(ocState == 0, "R4", ocState, 0);
    modeSel = 2'b11; tick = 1; step();
    modeSel = 2'b00; portBit = 0; tick = 1; step();
    check(ocState == 1, "R4", ocState, 1);
    check(pinOut == 0, "R5", pinOut, 0);
    portBit = 1; #1;
    check(pinOut == 1, "R5", pinOut, 1);
    modeSel = 2'b01; dirBit = 0; #1;
    check(pinOut == 0, "R5", pinOut, 0);
    dirBit = 1;
  endtask

  task automatic t_mode_now();
    modeSel = 2'b10; tick = 1; step();
    clearFlag();
    modeSel = 2'b11; tick = 1; step();
    check(ocState == 1, "R9", ocState, 1);
  endtask

  task automatic t_force();
    clearFlag();
    cnt = 16'h0000; modeSel = 2'b01;
    forceStrobe = 1; step();
    check(ocState == 0, "R6", ocState, 0);
    check(matchFlag == 0, "R6", matchFlag, 0);
    pwmMode = 1; forceStrobe = 1; step();
    check(ocState == 0, "R6", ocState, 0);
    pwmMode = 0;
  endtask

  task automatic t_block();
    clearFlag();
    modeSel = 2'b01; cnt = 16'h1234;
    cntWrite = 1; step();
    step(); step(); step();
    tick = 1; step();
    check(matchFlag == 0, "R7", matchFlag, 0);
    check(ocState == 0, "R7", ocState, 0);
    tick = 1; step();
    check(matchFlag == 1, "R7", matchFlag, 1);
    check(ocState == 1, "R7", ocState, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_match();
    t_mode_now();
    t_force();
    t_block();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule